// File: doc/BRIEF.md
# PCI Inbound DMA Window Translator

This block maps addresses that arrive from a PCI bus into system memory addresses. Software programs a set of windows, four by default. Each window has a match base, a size mask and a target base. An inbound address that falls inside an enabled window is translated in one of two ways. In direct mode the target base is added to the offset within the window. In scatter-gather mode the target base points at a page table in memory, and the offset selects a table entry that supplies the physical page frame.

Scatter-gather entries are held in a small tagged cache. Each cache line covers four consecutive table entries. On a miss the block issues one aligned read for the whole group of four and holds the translate port until the data returns. It then repeats the lookup. Software can drop the whole cache with one register write. A second register drops only the lines whose inbound address bits 31:16 match the written value.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset the translate port is ready, no result is valid, no memory read is requested, and every register reads zero, except that window 3's base register reads 0x00000002.
- R2: Window w hits when its enable bit (base bit 0) is set and the address bits 31:20 equal the base bits 31:20 at every position where mask bits 31:20 are zero. An address that hits no window completes with `res_nohit`=1.
- R3: When several enabled windows hit, the translation uses the window with the lowest index.
- R4: A direct window (base bit 1 clear) returns target base + (address AND {mask[31:20], 20'hFFFFF}), with `res_miss`=0 and `res_err`=0.
- R5: Window 3 always translates through the page table. Its base bit 1 is fixed and reads as 1, whatever value is written to it.
- R6: On a scatter-gather miss the block issues one read at (target base + 16*floor(page index/4)), aligned to 16 bytes, where page index = window offset >> PAGE_SHIFT. The address and the request stay stable until `mem_rvalid`. Entry k of the group is `mem_rdata[32k+31:32k]`.
- R7: A valid entry (bit 0 = 1) yields the address {entry[31:1], address[PAGE_SHIFT-1:0]}. A later access to the same four-page group then completes with no memory read and `res_miss`=0.
- R8: An invalid entry completes with `res_err`=1 and is not cached, so every access to that page issues a new read.
- R9: Writing any value to register 12 removes every cached entry.
- R10: A write of value V to register 13 removes the lines whose inbound address bits 31:16 equal V[19:4]. Other lines are kept.
- R11: A request is taken when `xl_valid` and `xl_ready` are both 1. `xl_ready` stays 0 until the result is given. A result that needs no memory read appears as a one-cycle `res_valid` pulse in the cycle after acceptance.
- R12: Register map: base of window w at w, mask at 4+w, target base at 8+w. Base bits 19:2 and mask bits 19:0 read zero, and target base bits 3:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| xl_valid | input | 1 | Translate request |
| xl_addr | input | 32 | Inbound PCI address |
| xl_ready | output | 1 | Port can take a request |
| res_valid | output | 1 | One-cycle result strobe |
| res_addr | output | 32 | Translated address |
| res_nohit | output | 1 | No window matched |
| res_miss | output | 1 | Result needed a page table read |
| res_err | output | 1 | Page table entry invalid |
| mem_req | output | 1 | Page table group read request |
| mem_addr | output | 32 | Byte address of the group |
| mem_rdata | input | 128 | Four entries returned |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The bench uses the default parameters: four windows, window 3 scatter-gather only, 8 KB pages, 32-bit entries and four cache lines. With these values a 16-page sweep fills every cache line exactly once. The bench's memory model computes each entry from its address, and every eighth entry is marked invalid. Each page's expected address, miss flag, error flag and fetch address are therefore computed arithmetically. The two windows overlap, and one window is disabled while the other stays enabled. Together these cover priority order, disable handling and both invalidate paths.

// File: rtl/dwx_pkg.sv
package dwx_pkg;
   localparam int ADDR_W   = 32;
   localparam int WIN_GRAN = 20;
   localparam int HI_W     = ADDR_W - WIN_GRAN;

   typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FETCH} dwx_state_e;

   typedef struct packed {
      logic              en;
      logic              sg;
      logic [HI_W-1:0]   base_hi;
      logic [HI_W-1:0]   mask_hi;
      logic [ADDR_W-1:0] tb;
   } win_cfg_t;
endpackage

// File: rtl/dwx_regs.sv
module dwx_regs #(
   parameter int              NWIN    = 4,
   parameter logic [NWIN-1:0] SG_ONLY = 4'b1000,
   parameter int              RA_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [RA_W-1:0]     addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   output dwx_pkg::win_cfg_t   cfg [NWIN],
   output logic                inv_all,
   output logic                inv_tag_en,
   output logic [15:0]         inv_tag
);
   import dwx_pkg::*;

   localparam int OFS_MASK = NWIN;
   localparam int OFS_TB   = 2 * NWIN;
   localparam int OFS_IALL = 3 * NWIN;
   localparam int OFS_ITAG = 3 * NWIN + 1;

   logic [HI_W-1:0] base_hi [NWIN];
   logic [HI_W-1:0] mask_hi [NWIN];
   logic [27:0]     tb_hi   [NWIN];
   logic [NWIN-1:0] en_q;
   logic [NWIN-1:0] sg_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         for (int w = 0; w < NWIN; w++) begin
            base_hi[w] <= '0;
            mask_hi[w] <= '0;
            tb_hi[w]   <= '0;
         end
      end else if (wr_en) begin
         for (int w = 0; w < NWIN; w++) begin
            if (addr == RA_W'(w)) begin
               base_hi[w] <= wdata[31:WIN_GRAN];
               en_q[w]    <= wdata[0];
            end
            if (addr == RA_W'(OFS_MASK + w)) mask_hi[w] <= wdata[31:WIN_GRAN];
            if (addr == RA_W'(OFS_TB + w))   tb_hi[w]   <= wdata[31:4];
         end
      end
   end

   for (genvar w = 0; w < NWIN; w++) begin : g_mode
      if (SG_ONLY[w]) begin : g_fixed
         assign sg_w[w] = 1'b1;
      end else begin : g_prog
         logic sg_b;
         always_ff @(posedge clk) begin
            if (!rst_n)                               sg_b <= 1'b0;
            else if (wr_en && addr == RA_W'(w))       sg_b <= wdata[1];
         end
         assign sg_w[w] = sg_b;
      end
   end

   always_comb begin
      for (int w = 0; w < NWIN; w++) begin
         cfg[w].en      = en_q[w];
         cfg[w].sg      = sg_w[w];
         cfg[w].base_hi = base_hi[w];
         cfg[w].mask_hi = mask_hi[w];
         cfg[w].tb      = {tb_hi[w], 4'h0};
      end
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (addr == RA_W'(w))
            rdata = {base_hi[w], {(WIN_GRAN-2){1'b0}}, sg_w[w], en_q[w]};
         if (addr == RA_W'(OFS_MASK + w))
            rdata = {mask_hi[w], {WIN_GRAN{1'b0}}};
         if (addr == RA_W'(OFS_TB + w))
            rdata = {tb_hi[w], 4'h0};
      end
   end

   assign inv_all    = wr_en && (addr == RA_W'(OFS_IALL));
   assign inv_tag_en = wr_en && (addr == RA_W'(OFS_ITAG));
   assign inv_tag    = wdata[19:4];
endmodule

// File: rtl/dwx_win_match.sv
module dwx_win_match #(
   parameter int NWIN  = 4,
   parameter int IDX_W = 2
) (
   input  logic [31:0]         addr,
   input  dwx_pkg::win_cfg_t   cfg [NWIN],
   output logic                hit_any,
   output logic [IDX_W-1:0]    idx,
   output logic                sg,
   output logic [31:0]         off,
   output logic [31:0]         tb
);
   import dwx_pkg::*;

   logic [NWIN-1:0] hit;

   for (genvar w = 0; w < NWIN; w++) begin : g_cmp
      assign hit[w] = cfg[w].en &&
         (((addr[31:WIN_GRAN] ^ cfg[w].base_hi) & ~cfg[w].mask_hi) == '0);
   end

   always_comb begin
      hit_any = 1'b0;
      idx     = '0;
      for (int w = NWIN - 1; w >= 0; w--) begin
         if (hit[w]) begin
            hit_any = 1'b1;
            idx     = IDX_W'(w);
         end
      end
   end

   always_comb begin
      sg  = cfg[idx].sg;
      tb  = cfg[idx].tb;
      off = addr & {cfg[idx].mask_hi, {WIN_GRAN{1'b1}}};
   end

   always_comb begin
      if (hit_any) begin
         assert_lowest_win_R3: assert (hit[idx] && ((hit & ((NWIN'(1) << idx) - NWIN'(1))) == '0));
      end
   end
endmodule

// File: rtl/dwx_pte_cache.sv
module dwx_pte_cache #(
   parameter int LINES = 4,
   parameter int PTE_W = 32,
   parameter int TAG_W = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAG_W-1:0]   tag,
   input  logic [1:0]         sel,
   output logic               hit,
   output logic [PTE_W-1:0]   pte,
   input  logic               fill_en,
   input  logic [4*PTE_W-1:0] fill_data,
   input  logic               inv_all,
   input  logic               inv_tag_en,
   input  logic [15:0]        inv_tag
);
   localparam int LI_W = (LINES > 1) ? $clog2(LINES) : 1;

   logic [LINES-1:0] lv;
   logic [TAG_W-1:0] ltag [LINES];
   logic [3:0]       lev  [LINES];
   logic [PTE_W-1:0] lpte [LINES][4];
   logic [LI_W-1:0]  rr;
   logic [LINES-1:0] tm_vec;
   logic             tm_any;
   logic [LI_W-1:0]  tm_idx;
   logic [LI_W-1:0]  victim;

   always_comb begin
      hit    = 1'b0;
      pte    = '0;
      tm_any = 1'b0;
      tm_idx = '0;
      for (int l = 0; l < LINES; l++) begin
         tm_vec[l] = lv[l] && (ltag[l] == tag);
         if (tm_vec[l]) begin
            tm_any = 1'b1;
            tm_idx = LI_W'(l);
            if (lev[l][sel]) begin
               hit = 1'b1;
               pte = lpte[l][sel];
            end
         end
      end
   end

   assign victim = tm_any ? tm_idx : rr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lv <= '0;
         rr <= '0;
      end else begin
         if (inv_all) begin
            lv <= '0;
         end else if (inv_tag_en) begin
            for (int l = 0; l < LINES; l++)
               if (ltag[l][TAG_W-1 -: 16] == inv_tag) lv[l] <= 1'b0;
         end
         if (fill_en) begin
            lv[victim] <= 1'b1;
            if (!tm_any) rr <= (rr == LI_W'(LINES - 1)) ? '0 : rr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         ltag[victim] <= tag;
         for (int k = 0; k < 4; k++) begin
            lev[victim][k]  <= fill_data[k*PTE_W];
            lpte[victim][k] <= fill_data[k*PTE_W +: PTE_W];
         end
      end
   end

   assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !fill_en) |=> (lv == '0));
   assert_unique_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tm_vec) <= 1);
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate #(
   parameter int              NWIN       = 4,
   parameter logic [NWIN-1:0] SG_ONLY    = 4'b1000,
   parameter int              PAGE_SHIFT = 13,
   parameter int              PTE_W      = 32,
   parameter int              LINES      = 4,
   parameter int              PA_W       = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [3:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               xl_valid,
   input  logic [31:0]        xl_addr,
   output logic               xl_ready,
   output logic               res_valid,
   output logic [PA_W-1:0]    res_addr,
   output logic               res_nohit,
   output logic               res_miss,
   output logic               res_err,
   output logic               mem_req,
   output logic [31:0]        mem_addr,
   input  logic [4*PTE_W-1:0] mem_rdata,
   input  logic               mem_rvalid
);
   import dwx_pkg::*;

   localparam int RA_W      = 4;
   localparam int IDX_W     = (NWIN > 1) ? $clog2(NWIN) : 1;
   localparam int GRP_SHIFT = PAGE_SHIFT + 2;
   localparam int TAG_W     = ADDR_W - GRP_SHIFT;
   localparam int GRP_BYTES = 4 * PTE_W / 8;
   localparam int WIDE_W    = PTE_W - 1 + PAGE_SHIFT;

   if (3 * NWIN + 2 > (1 << RA_W)) begin : g_chk_map
      $error("register map does not fit the index width");
   end
   if (PAGE_SHIFT < 12 || GRP_SHIFT > 16) begin : g_chk_page
      $error("page shift must keep a group within a 64 KB tag");
   end
   if (GRP_BYTES > 16 || PTE_W % 8 != 0) begin : g_chk_pte
      $error("entry group must fit the 16-byte target alignment");
   end
   if (PA_W > WIDE_W) begin : g_chk_pa
      $error("output width exceeds frame plus page offset");
   end

   win_cfg_t       cfg [NWIN];
   logic           inv_all, inv_tag_en;
   logic [15:0]    inv_tag;

   dwx_regs #(.NWIN(NWIN), .SG_ONLY(SG_ONLY), .RA_W(RA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg),
      .inv_all(inv_all), .inv_tag_en(inv_tag_en), .inv_tag(inv_tag));

   dwx_state_e  st;
   logic [31:0] cur_addr;
   logic        fetched;
   logic [31:0] maddr_q;

   logic             wm_hit, wm_sg;
   logic [IDX_W-1:0] wm_idx;
   logic [31:0]      wm_off, wm_tb;

   dwx_win_match #(.NWIN(NWIN), .IDX_W(IDX_W)) u_match (
      .addr(cur_addr), .cfg(cfg), .hit_any(wm_hit), .idx(wm_idx),
      .sg(wm_sg), .off(wm_off), .tb(wm_tb));

   logic             c_hit;
   logic [PTE_W-1:0] c_pte;
   logic             fill_en;

   assign fill_en = (st == ST_FETCH) && mem_rvalid;

   dwx_pte_cache #(.LINES(LINES), .PTE_W(PTE_W), .TAG_W(TAG_W)) u_cache (
      .clk(clk), .rst_n(rst_n), .tag(cur_addr[31:GRP_SHIFT]),
      .sel(wm_off[PAGE_SHIFT+1:PAGE_SHIFT]), .hit(c_hit), .pte(c_pte),
      .fill_en(fill_en), .fill_data(mem_rdata), .inv_all(inv_all),
      .inv_tag_en(inv_tag_en), .inv_tag(inv_tag));

   logic [31:0]       direct_sum;
   logic [WIDE_W-1:0] sg_wide;
   logic [31:0]       grp_addr;

   assign direct_sum = wm_tb + wm_off;
   assign sg_wide    = {c_pte[PTE_W-1:1], cur_addr[PAGE_SHIFT-1:0]};
   assign grp_addr   = (wm_tb + ((wm_off >> GRP_SHIFT) * 32'(GRP_BYTES)))
                       & ~32'(GRP_BYTES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_addr  <= '0;
         fetched   <= 1'b0;
         maddr_q   <= '0;
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_nohit <= 1'b0;
         res_miss  <= 1'b0;
         res_err   <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (xl_valid) begin
                  cur_addr <= xl_addr;
                  fetched  <= 1'b0;
                  st       <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               if (!wm_hit) begin
                  res_valid <= 1'b1;
                  res_nohit <= 1'b1;
                  res_err   <= 1'b0;
                  res_miss  <= 1'b0;
                  res_addr  <= '0;
                  st        <= ST_IDLE;
               end else if (!wm_sg) begin
                  res_valid <= 1'b1;
                  res_nohit <= 1'b0;
                  res_err   <= 1'b0;
                  res_miss  <= 1'b0;
                  res_addr  <= PA_W'(direct_sum);
                  st        <= ST_IDLE;
               end else if (c_hit) begin
                  res_valid <= 1'b1;
                  res_nohit <= 1'b0;
                  res_err   <= 1'b0;
                  res_miss  <= fetched;
                  res_addr  <= sg_wide[PA_W-1:0];
                  st        <= ST_IDLE;
               end else if (fetched) begin
                  res_valid <= 1'b1;
                  res_nohit <= 1'b0;
                  res_err   <= 1'b1;
                  res_miss  <= 1'b1;
                  res_addr  <= '0;
                  st        <= ST_IDLE;
               end else begin
                  maddr_q <= grp_addr;
                  st      <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_rvalid) begin
                  fetched <= 1'b1;
                  st      <= ST_LOOK;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign xl_ready = (st == ST_IDLE);
   assign mem_req  = (st == ST_FETCH);
   assign mem_addr = maddr_q;

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
   assert_req_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr & 32'(GRP_BYTES - 1)) == '0));
   assert_take_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && xl_ready) |=> !xl_ready);
   assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !xl_ready);
   assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !(res_err && res_nohit));
endmodule

// File: tb/dma_win_xlate_bench.sv
`timescale 1ns/1ps
module dma_win_xlate_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         xl_valid = 1'b0;
   logic [31:0]  xl_addr = '0;
   logic         xl_ready, res_valid, res_nohit, res_miss, res_err, mem_req;
   logic [31:0]  res_addr, mem_addr;
   logic [127:0] mem_rdata = '0;
   logic         mem_rvalid = 1'b0;

   int checks = 0;
   int errors = 0;
   int fetch_cnt = 0;
   logic [31:0] last_fetch = '0;
   logic        mbusy = 1'b0;
   int          mcnt = 0;
   logic [31:0] maddr = '0;

   always #2.5 clk = ~clk;

   dma_win_xlate u_dma_win_xlate (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_valid(xl_valid),
      .xl_addr(xl_addr), .xl_ready(xl_ready), .res_valid(res_valid),
      .res_addr(res_addr), .res_nohit(res_nohit), .res_miss(res_miss),
      .res_err(res_err), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid));

   function automatic logic [31:0] pte_of(input logic [31:0] ba);
      logic [31:0] idx;
      idx = ba >> 2;
      return (((idx ^ 32'h155) & 32'hFFFF) << 1) | {31'd0, idx[2:0] != 3'd5};
   endfunction

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (!rst_n) begin
         mbusy <= 1'b0;
      end else if (mbusy) begin
         if (mcnt == 0) begin
            mem_rvalid <= 1'b1;
            for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] <= pte_of(maddr + 32'(4*k));
            mbusy <= 1'b0;
         end else begin
            mcnt <= mcnt - 1;
         end
      end else if (mem_req && !mem_rvalid) begin
         mbusy      <= 1'b1;
         mcnt       <= 2;
         maddr      <= mem_addr;
         fetch_cnt  <= fetch_cnt + 1;
         last_fetch <= mem_addr;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic xl(input logic [31:0] a, input bit e_nohit, input bit e_err,
                     input bit e_miss, input logic [31:0] e_addr,
                     input logic [31:0] e_fetch, input string req);
      int f0;
      int n;
      @(negedge clk);
      chk(xl_ready == 1'b1, "R11 ready", {31'd0, xl_ready}, 32'd1);
      f0 = fetch_cnt;
      xl_valid = 1'b1; xl_addr = a;
      @(negedge clk);
      xl_valid = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (!res_valid && n < 40) chk(xl_ready == 1'b0, "R11 stall", {31'd0, xl_ready}, 32'd0);
      end while (!res_valid && n < 40);
      chk(res_valid == 1'b1, {req, " valid"}, {31'd0, res_valid}, 32'd1);
      chk(res_nohit == e_nohit, {req, " nohit"}, {31'd0, res_nohit}, {31'd0, e_nohit});
      chk(res_err == e_err, {req, " err"}, {31'd0, res_err}, {31'd0, e_err});
      chk(res_miss == e_miss, {req, " miss"}, {31'd0, res_miss}, {31'd0, e_miss});
      chk((fetch_cnt - f0) == int'(e_miss), {req, " reads"}, 32'(fetch_cnt - f0), {31'd0, e_miss});
      if (!e_nohit && !e_err) chk(res_addr == e_addr, {req, " addr"}, res_addr, e_addr);
      if (e_miss) chk(last_fetch == e_fetch, {req, " R6 read addr"}, last_fetch, e_fetch);
      else chk(n == 1, {req, " R11 latency"}, 32'(n), 32'd1);
   endtask

   task automatic sg_page(input logic [31:0] win, input logic [31:0] tb, input int p,
                          input logic [31:0] lo, input bit cached, input string req);
      logic [31:0] a, pte, e;
      a   = win + 32'(p) * 32'h2000 + (lo & 32'h1FFF);
      pte = pte_of(tb + 32'(p) * 4);
      e   = ((pte >> 1) << 13) | (a & 32'h1FFF);
      xl(a, 1'b0, !pte[0], !pte[0] || !cached, e, tb + 32'(p / 4) * 16, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(xl_ready == 1'b1, "R1 ready", {31'd0, xl_ready}, 32'd1);
      chk(res_valid == 1'b0, "R1 res_valid", {31'd0, res_valid}, 32'd0);
      chk(mem_req == 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'd0);
      rd(4'd0, 32'h0, "R1 base0");
      rd(4'd8, 32'h0, "R1 tb0");
      rd(4'd3, 32'h2, "R1 base3");

      // R12 field widths
      wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, 32'hFFF0_0003, "R12 base");
      wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, 32'hFFF0_0000, "R12 mask");
      wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, 32'hFFFF_FFF0, "R12 tb");
      // R5 window 3 forced to page-table mode
      wr(4'd3, 32'h3000_0001); rd(4'd3, 32'h3000_0003, "R5 base3");

      wr(4'd0, 32'h1000_0001); wr(4'd4, 32'h0010_0000); wr(4'd8, 32'h4000_0000);
      wr(4'd1, 32'h2000_0003); wr(4'd5, 32'h0);         wr(4'd9, 32'h0008_0000);
      wr(4'd2, 32'h1000_0001); wr(4'd6, 32'h0);         wr(4'd10, 32'h7000_0000);
      wr(4'd7, 32'h0);         wr(4'd11, 32'h000C_0000);

      // R4 direct sweep across the 2 MB window
      for (int k = 0; k < 17; k++) begin
         logic [31:0] off;
         off = 32'(k) * 32'h1F3C1;
         xl(32'h1000_0000 + off, 1'b0, 1'b0, 1'b0, 32'h4000_0000 + off, 32'h0, "R4 direct");
      end
      // R2 no match
      xl(32'h5000_0000, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, "R2 nohit");
      xl(32'h1020_0000, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, "R2 nohit edge");
      // R3 overlap: window 0 wins
      xl(32'h1000_0040, 1'b0, 1'b0, 1'b0, 32'h4000_0040, 32'h0, "R3 priority");
      // R2 disabled window 0 is skipped
      wr(4'd0, 32'h1000_0000);
      xl(32'h1000_0040, 1'b0, 1'b0, 1'b0, 32'h7000_0040, 32'h0, "R2 disabled");
      wr(4'd0, 32'h1000_0001);

      // R6 R7 R8 first page-table sweep: one read per group
      for (int p = 0; p < 16; p++) sg_page(32'h2000_0000, 32'h0008_0000, p, 32'(p) * 32'h123, p % 4 != 0, "R6 sweep");
      // R7 R8 second sweep: valid entries cached, invalid refetched
      for (int p = 0; p < 16; p++) sg_page(32'h2000_0000, 32'h0008_0000, p, 32'(p) * 32'h77, 1'b1, "R7 cached");
      // R5 window 3 translates through its table
      sg_page(32'h3000_0000, 32'h000C_0000, 2, 32'h55, 1'b0, "R5 sg3");

      // R9 invalidate all
      wr(4'd12, 32'h0);
      sg_page(32'h2000_0000, 32'h0008_0000, 1, 32'h10, 1'b0, "R9 flushed");
      sg_page(32'h2000_0000, 32'h0001_0000 + 32'h0007_0000, 8, 32'h20, 1'b0, "R9 flushed");
      // R10 invalidate by tag 0x2000 keeps 0x2001 lines
      wr(4'd13, 32'h2000_0000 >> 12);
      sg_page(32'h2000_0000, 32'h0008_0000, 8, 32'h30, 1'b1, "R10 kept");
      sg_page(32'h2000_0000, 32'h0008_0000, 1, 32'h40, 1'b0, "R10 dropped");

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule